// File: doc/BRIEF.md
# Register Rename Undo Journal

This block keeps an ordered journal of every destination-register remapping made by a rename stage. Each journal record holds the instruction's sequence number, the architectural register it wrote, the physical register it was newly given and the physical register that mapping replaced. The journal serves two purposes. It can unwind speculative remappings when younger work is thrown away. It can also hand back superseded physical registers once the instructions that replaced them retire.

The journal is a circular queue. Records enter at the young end. A squash request names a sequence number, and the block then walks back from the young end one record per cycle. For each record it rewrites the map-table entry to the older physical register and returns the new one to the free list. Physical registers whose index falls at or above the count of ordinary physical registers also get their ready bit set in the scoreboard. A commit request also names a sequence number. The block then drains from the old end one record per cycle and returns each superseded physical register to the free list. The block also tells the rename stage when a renaming may proceed at all: there must be journal space, no walk in progress and enough free physical registers for the instruction's destinations.

Top module: `rhj_top`

## Requirements
- R1: An accepted record (rec_valid high while rename_grant is high) is stored at the young end. The cycle after, sb_clr_valid pulses with sb_clr_preg equal to the new physical register.
- R2: After squash_valid, records whose sequence number is greater than squash_seq are removed youngest first, one per cycle. Each removal pulses map_wr_valid with map_wr_areg/map_wr_preg equal to its architectural and previous physical register, and in the same cycle pulses fl_ret_valid with its new physical register. Records with sequence number less than or equal to squash_seq stay.
- R3: During a rollback removal whose new physical register index is at least NUM_PHYS (96 by default), sb_set_valid pulses with that register in the same cycle as its fl_ret pulse. Lower indices never raise sb_set_valid.
- R4: After commit_valid, records whose sequence number is less than or equal to commit_seq are removed oldest first, one per cycle. Each removal pulses fl_ret_valid with its previous physical register and leaves map_wr_valid low.
- R5: A commit request is dropped when the journal is empty or when its oldest record has a sequence number greater than commit_seq. No output pulses and busy stays low.
- R6: A commit request arriving in a cycle with squash_valid or squashing high is dropped. A release walk in progress makes no removal in any cycle where squashing is high.
- R7: rename_grant is high only when the journal is not full, busy and squash_valid are low, and free_count is at least rec_dst_count.
- R8: busy is high from the cycle after an accepted squash or commit request until the walk ends. A squash always starts a walk, even when nothing is removed.
- R9: After reset the journal is empty, busy is low and every output pulse is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_valid | input | 1 | Record request for one destination remapping |
| rec_seq | input | SEQ_W | Sequence number of the renamed instruction |
| rec_areg | input | AREG_W | Architectural destination register |
| rec_new_preg | input | PREG_W | Newly allocated physical register |
| rec_prev_preg | input | PREG_W | Physical register previously mapped |
| rec_dst_count | input | NEED_W | Destination count of the instruction |
| free_count | input | FREE_W | Free physical registers available |
| rename_grant | output | 1 | Renaming may proceed this cycle |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Youngest surviving sequence number |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Youngest retired sequence number |
| squashing | input | 1 | Thread is in a squash period |
| busy | output | 1 | A walk is in progress |
| map_wr_valid | output | 1 | Map-table restore write |
| map_wr_areg | output | AREG_W | Restored architectural register |
| map_wr_preg | output | PREG_W | Physical register restored into the map |
| fl_ret_valid | output | 1 | Free-list return |
| fl_ret_preg | output | PREG_W | Returned physical register |
| sb_set_valid | output | 1 | Scoreboard mark-ready |
| sb_set_preg | output | PREG_W | Register marked ready |
| sb_clr_valid | output | 1 | Scoreboard mark-not-ready |
| sb_clr_preg | output | PREG_W | Register marked not ready |

## Verification
The assertions assume that sequence numbers arrive in increasing order at the record port, that they never wrap, and that rec_valid is only raised when rename_grant is high. The stimulus keeps to this by using strictly rising sequence numbers well below the counter limit, and by having the record task drive a request only after it has seen the grant. Squash and commit requests are single-cycle pulses. The bench waits for busy to fall before it issues the next request, except in the deliberate cases where a commit coincides with a squash or with the squashing level.

// File: rtl/rhj_pkg.sv
package rhj_pkg;
    typedef enum logic [1:0] {
        WM_IDLE     = 2'd0,
        WM_ROLLBACK = 2'd1,
        WM_RELEASE  = 2'd2
    } walk_mode_e;
endpackage

// File: rtl/rhj_ring.sv
module rhj_ring #(
    parameter int DEPTH  = 8,
    parameter int SEQ_W  = 16,
    parameter int AREG_W = 5,
    parameter int PREG_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [SEQ_W-1:0]  push_seq,
    input  logic [AREG_W-1:0] push_areg,
    input  logic [PREG_W-1:0] push_new,
    input  logic [PREG_W-1:0] push_prev,
    input  logic              pop_young,
    input  logic              pop_old,
    output logic [SEQ_W-1:0]  young_seq,
    output logic [AREG_W-1:0] young_areg,
    output logic [PREG_W-1:0] young_new,
    output logic [PREG_W-1:0] young_prev,
    output logic [SEQ_W-1:0]  old_seq,
    output logic [PREG_W-1:0] old_prev,
    output logic              empty,
    output logic              full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
        logic [CNT_W-1:0] cnt;
    } ptr_t;

    ptr_t p_d, p_q;

    logic [SEQ_W-1:0]  seq_q  [DEPTH];
    logic [AREG_W-1:0] areg_q [DEPTH];
    logic [PREG_W-1:0] new_q  [DEPTH];
    logic [PREG_W-1:0] prev_q [DEPTH];

    logic [PTR_W-1:0] young_idx;

    function automatic logic [PTR_W-1:0] step_up(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + PTR_W'(1);
    endfunction

    function automatic logic [PTR_W-1:0] step_down(input logic [PTR_W-1:0] p);
        return (p == '0) ? LAST : p - PTR_W'(1);
    endfunction

    assign young_idx  = step_down(p_q.tail);
    assign young_seq  = seq_q[young_idx];
    assign young_areg = areg_q[young_idx];
    assign young_new  = new_q[young_idx];
    assign young_prev = prev_q[young_idx];
    assign old_seq    = seq_q[p_q.head];
    assign old_prev   = prev_q[p_q.head];
    assign empty      = (p_q.cnt == '0);
    assign full       = (p_q.cnt == CAP);

    always_comb begin
        p_d = p_q;
        if (push) begin
            p_d.tail = step_up(p_q.tail);
            p_d.cnt  = p_q.cnt + CNT_W'(1);
        end else if (pop_young) begin
            p_d.tail = young_idx;
            p_d.cnt  = p_q.cnt - CNT_W'(1);
        end else if (pop_old) begin
            p_d.head = step_up(p_q.head);
            p_d.cnt  = p_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (push) begin
            seq_q[p_q.tail]  <= push_seq;
            areg_q[p_q.tail] <= push_areg;
            new_q[p_q.tail]  <= push_new;
            prev_q[p_q.tail] <= push_prev;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);  // R7
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_young || pop_old) |-> !empty);  // R2
    AST_PUSH_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !(pop_young || pop_old));  // R1
endmodule

// File: rtl/rhj_walker.sv
module rhj_walker
    import rhj_pkg::*;
#(
    parameter int SEQ_W    = 16,
    parameter int AREG_W   = 5,
    parameter int PREG_W   = 7,
    parameter int NUM_PHYS = 96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [PREG_W-1:0] push_new,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    input  logic              commit_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              squashing,
    input  logic              empty,
    input  logic [SEQ_W-1:0]  young_seq,
    input  logic [AREG_W-1:0] young_areg,
    input  logic [PREG_W-1:0] young_new,
    input  logic [PREG_W-1:0] young_prev,
    input  logic [SEQ_W-1:0]  old_seq,
    input  logic [PREG_W-1:0] old_prev,
    output logic              pop_young,
    output logic              pop_old,
    output logic              busy,
    output logic              map_v,
    output logic [AREG_W-1:0] map_areg,
    output logic [PREG_W-1:0] map_preg,
    output logic              free_v,
    output logic [PREG_W-1:0] free_preg,
    output logic              set_v,
    output logic [PREG_W-1:0] set_preg,
    output logic              clr_v,
    output logic [PREG_W-1:0] clr_preg
);
    localparam logic [PREG_W-1:0] SPECIAL_BASE = PREG_W'(NUM_PHYS);

    typedef struct packed {
        walk_mode_e        mode;
        logic [SEQ_W-1:0]  target;
        logic              map_v;
        logic [AREG_W-1:0] map_areg;
        logic [PREG_W-1:0] map_preg;
        logic              free_v;
        logic [PREG_W-1:0] free_preg;
        logic              set_v;
        logic [PREG_W-1:0] set_preg;
        logic              clr_v;
        logic [PREG_W-1:0] clr_preg;
    } wstate_t;

    wstate_t s_d, s_q;
    logic    commit_ok;

    assign commit_ok = commit_valid && !squash_valid && !squashing
                       && !empty && (old_seq <= commit_seq);

    always_comb begin
        s_d        = s_q;
        s_d.map_v  = 1'b0;
        s_d.free_v = 1'b0;
        s_d.set_v  = 1'b0;
        s_d.clr_v  = 1'b0;
        pop_young  = 1'b0;
        pop_old    = 1'b0;

        if (push) begin
            s_d.clr_v    = 1'b1;
            s_d.clr_preg = push_new;
        end

        unique case (s_q.mode)
            WM_ROLLBACK: begin
                if (!squash_valid) begin
                    if (!empty && (young_seq > s_q.target)) begin
                        pop_young     = 1'b1;
                        s_d.map_v     = 1'b1;
                        s_d.map_areg  = young_areg;
                        s_d.map_preg  = young_prev;
                        s_d.free_v    = 1'b1;
                        s_d.free_preg = young_new;
                        if (young_new >= SPECIAL_BASE) begin
                            s_d.set_v    = 1'b1;
                            s_d.set_preg = young_new;
                        end
                    end else begin
                        s_d.mode = WM_IDLE;
                    end
                end
            end
            WM_RELEASE: begin
                if (!squash_valid && !squashing) begin
                    if (!empty && (old_seq <= s_q.target)) begin
                        pop_old       = 1'b1;
                        s_d.free_v    = 1'b1;
                        s_d.free_preg = old_prev;
                    end else begin
                        s_d.mode = WM_IDLE;
                    end
                end
            end
            default: ;
        endcase

        if (squash_valid) begin
            s_d.mode   = WM_ROLLBACK;
            s_d.target = squash_seq;
        end else if (s_q.mode == WM_IDLE && commit_ok) begin
            s_d.mode   = WM_RELEASE;
            s_d.target = commit_seq;
        end else if (s_q.mode == WM_RELEASE && commit_valid && !squashing
                     && (commit_seq > s_q.target)) begin
            s_d.target = commit_seq;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy      = (s_q.mode != WM_IDLE);
    assign map_v     = s_q.map_v;
    assign map_areg  = s_q.map_areg;
    assign map_preg  = s_q.map_preg;
    assign free_v    = s_q.free_v;
    assign free_preg = s_q.free_preg;
    assign set_v     = s_q.set_v;
    assign set_preg  = s_q.set_preg;
    assign clr_v     = s_q.clr_v;
    assign clr_preg  = s_q.clr_preg;

    AST_SPECIAL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        set_v |-> (free_v && map_v && set_preg == free_preg && set_preg >= SPECIAL_BASE));  // R3
    AST_RESTORE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        map_v |-> free_v);  // R2
    AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_valid || squashing) |=> !(free_v && !map_v));  // R6
    AST_SQUASH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |=> busy);  // R8
endmodule

// File: rtl/rhj_admit.sv
module rhj_admit #(
    parameter int FREE_W = 8,
    parameter int NEED_W = 2
) (
    input  logic              full,
    input  logic              busy,
    input  logic              squash_valid,
    input  logic [FREE_W-1:0] free_count,
    input  logic [NEED_W-1:0] dst_count,
    output logic              grant
);
    logic regs_ok;

    generate
        if (FREE_W >= NEED_W) begin : g_wide_free
            assign regs_ok = (free_count >= FREE_W'(dst_count));
        end else begin : g_wide_need
            assign regs_ok = (NEED_W'(free_count) >= dst_count);
        end
    endgenerate

    assign grant = regs_ok && !full && !busy && !squash_valid;
endmodule

// File: rtl/rhj_top.sv
module rhj_top #(
    parameter int DEPTH    = 8,
    parameter int SEQ_W    = 16,
    parameter int AREG_W   = 5,
    parameter int PREG_W   = 7,
    parameter int NUM_PHYS = 96,
    parameter int FREE_W   = 8,
    parameter int NEED_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rec_valid,
    input  logic [SEQ_W-1:0]  rec_seq,
    input  logic [AREG_W-1:0] rec_areg,
    input  logic [PREG_W-1:0] rec_new_preg,
    input  logic [PREG_W-1:0] rec_prev_preg,
    input  logic [NEED_W-1:0] rec_dst_count,
    input  logic [FREE_W-1:0] free_count,
    output logic              rename_grant,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    input  logic              commit_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              squashing,
    output logic              busy,
    output logic              map_wr_valid,
    output logic [AREG_W-1:0] map_wr_areg,
    output logic [PREG_W-1:0] map_wr_preg,
    output logic              fl_ret_valid,
    output logic [PREG_W-1:0] fl_ret_preg,
    output logic              sb_set_valid,
    output logic [PREG_W-1:0] sb_set_preg,
    output logic              sb_clr_valid,
    output logic [PREG_W-1:0] sb_clr_preg
);
    logic              push_w, pop_young_w, pop_old_w, empty_w, full_w;
    logic [SEQ_W-1:0]  young_seq_w, old_seq_w;
    logic [AREG_W-1:0] young_areg_w;
    logic [PREG_W-1:0] young_new_w, young_prev_w, old_prev_w;

    assign push_w = rec_valid && rename_grant;

    rhj_admit #(.FREE_W(FREE_W), .NEED_W(NEED_W)) admit_i (
        .full(full_w), .busy(busy), .squash_valid(squash_valid),
        .free_count(free_count), .dst_count(rec_dst_count), .grant(rename_grant)
    );

    rhj_ring #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .AREG_W(AREG_W), .PREG_W(PREG_W)) ring_i (
        .clk(clk), .rst_n(rst_n), .push(push_w), .push_seq(rec_seq),
        .push_areg(rec_areg), .push_new(rec_new_preg), .push_prev(rec_prev_preg),
        .pop_young(pop_young_w), .pop_old(pop_old_w),
        .young_seq(young_seq_w), .young_areg(young_areg_w),
        .young_new(young_new_w), .young_prev(young_prev_w),
        .old_seq(old_seq_w), .old_prev(old_prev_w),
        .empty(empty_w), .full(full_w)
    );

    rhj_walker #(.SEQ_W(SEQ_W), .AREG_W(AREG_W), .PREG_W(PREG_W), .NUM_PHYS(NUM_PHYS)) walk_i (
        .clk(clk), .rst_n(rst_n), .push(push_w), .push_new(rec_new_preg),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .commit_valid(commit_valid), .commit_seq(commit_seq), .squashing(squashing),
        .empty(empty_w), .young_seq(young_seq_w), .young_areg(young_areg_w),
        .young_new(young_new_w), .young_prev(young_prev_w),
        .old_seq(old_seq_w), .old_prev(old_prev_w),
        .pop_young(pop_young_w), .pop_old(pop_old_w), .busy(busy),
        .map_v(map_wr_valid), .map_areg(map_wr_areg), .map_preg(map_wr_preg),
        .free_v(fl_ret_valid), .free_preg(fl_ret_preg),
        .set_v(sb_set_valid), .set_preg(sb_set_preg),
        .clr_v(sb_clr_valid), .clr_preg(sb_clr_preg)
    );
endmodule

// File: tb/rhj_top_tb_top.sv
module rhj_top_tb_top;
    localparam int DEPTH = 8, SEQ_W = 16, AREG_W = 5, PREG_W = 7;
    localparam int NUM_PHYS = 96, FREE_W = 8, NEED_W = 2;

    typedef struct packed {
        logic              map_v;
        logic [AREG_W-1:0] map_areg;
        logic [PREG_W-1:0] map_preg;
        logic              free_v;
        logic [PREG_W-1:0] free_preg;
        logic              set_v;
        logic [PREG_W-1:0] set_preg;
        logic              clr_v;
        logic [PREG_W-1:0] clr_preg;
    } ev_t;

    typedef struct {
        int seq; int areg; int newp; int prevp;
    } ent_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic rec_valid = 0, squash_valid = 0, commit_valid = 0, squashing = 0;
    logic [SEQ_W-1:0]  rec_seq = '0, squash_seq = '0, commit_seq = '0;
    logic [AREG_W-1:0] rec_areg = '0;
    logic [PREG_W-1:0] rec_new_preg = '0, rec_prev_preg = '0;
    logic [NEED_W-1:0] rec_dst_count = 2'd1;
    logic [FREE_W-1:0] free_count = 8'd20;
    logic rename_grant, busy, map_wr_valid, fl_ret_valid, sb_set_valid, sb_clr_valid;
    logic [AREG_W-1:0] map_wr_areg;
    logic [PREG_W-1:0] map_wr_preg, fl_ret_preg, sb_set_preg, sb_clr_preg;

    int checks = 0, failures = 0;
    ev_t  expq[$];
    ent_t mq[$];

    always #2 clk = ~clk;

    rhj_top #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .AREG_W(AREG_W), .PREG_W(PREG_W),
              .NUM_PHYS(NUM_PHYS), .FREE_W(FREE_W), .NEED_W(NEED_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_seq(rec_seq),
        .rec_areg(rec_areg), .rec_new_preg(rec_new_preg), .rec_prev_preg(rec_prev_preg),
        .rec_dst_count(rec_dst_count), .free_count(free_count), .rename_grant(rename_grant),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .commit_valid(commit_valid), .commit_seq(commit_seq), .squashing(squashing),
        .busy(busy), .map_wr_valid(map_wr_valid), .map_wr_areg(map_wr_areg),
        .map_wr_preg(map_wr_preg), .fl_ret_valid(fl_ret_valid), .fl_ret_preg(fl_ret_preg),
        .sb_set_valid(sb_set_valid), .sb_set_preg(sb_set_preg),
        .sb_clr_valid(sb_clr_valid), .sb_clr_preg(sb_clr_preg)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic ev_t blank_ev();
        ev_t e;
        e = '0;
        return e;
    endfunction

    // Monitor: compares each output pulse cycle with the next expected item
    always @(negedge clk) begin
        if (rst_n && (map_wr_valid || fl_ret_valid || sb_set_valid || sb_clr_valid)) begin
            ev_t a;
            a = blank_ev();
            a.map_v = map_wr_valid;
            if (map_wr_valid) begin a.map_areg = map_wr_areg; a.map_preg = map_wr_preg; end
            a.free_v = fl_ret_valid;
            if (fl_ret_valid) a.free_preg = fl_ret_preg;
            a.set_v = sb_set_valid;
            if (sb_set_valid) a.set_preg = sb_set_preg;
            a.clr_v = sb_clr_valid;
            if (sb_clr_valid) a.clr_preg = sb_clr_preg;
            if (expq.size() == 0) begin
                chk(1'b0, "R2/R4/R5 unexpected output pulse", int'(a.free_preg), -1);
            end else begin
                ev_t e;
                e = expq.pop_front();
                chk(a == e, "R1/R2/R3/R4 output item", int'(a[31:0]), int'(e[31:0]));
            end
        end
    end

    task automatic record(input int seq, input int areg, input int newp, input int prevp);
        @(negedge clk);
        rec_seq = SEQ_W'(seq); rec_areg = AREG_W'(areg);
        rec_new_preg = PREG_W'(newp); rec_prev_preg = PREG_W'(prevp);
        rec_dst_count = 2'd1; free_count = 8'd20;
        #0.5;
        chk(rename_grant === 1'b1, "R7 grant before record", int'(rename_grant), 1);
        if (rename_grant) begin
            ev_t e;
            ent_t m;
            rec_valid = 1'b1;
            m.seq = seq; m.areg = areg; m.newp = newp; m.prevp = prevp;
            mq.push_back(m);
            e = blank_ev(); e.clr_v = 1'b1; e.clr_preg = PREG_W'(newp);   // R1
            expq.push_back(e);
        end
        @(posedge clk); #1;
        rec_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int n;
        n = 0;
        while (busy && n < 100) begin @(negedge clk); n++; end
        @(negedge clk);
        chk(busy === 1'b0, "R8 walk ends", int'(busy), 0);
    endtask

    task automatic model_rollback(input int s);
        while (mq.size() > 0 && mq[mq.size()-1].seq > s) begin
            ev_t e;
            ent_t m;
            m = mq.pop_back();
            e = blank_ev();
            e.map_v = 1'b1; e.map_areg = AREG_W'(m.areg); e.map_preg = PREG_W'(m.prevp);
            e.free_v = 1'b1; e.free_preg = PREG_W'(m.newp);
            if (m.newp >= NUM_PHYS) begin e.set_v = 1'b1; e.set_preg = PREG_W'(m.newp); end
            expq.push_back(e);
        end
    endtask

    function automatic int model_release(input int c);
        int n;
        n = 0;
        while (mq.size() > 0 && mq[0].seq <= c) begin
            ev_t e;
            ent_t m;
            m = mq.pop_front();
            e = blank_ev(); e.free_v = 1'b1; e.free_preg = PREG_W'(m.prevp);
            expq.push_back(e);
            n++;
        end
        return n;
    endfunction

    task automatic do_squash(input int s, input bit with_commit, input int c);
        model_rollback(s);
        @(negedge clk);
        squash_valid = 1'b1; squash_seq = SEQ_W'(s);
        commit_valid = with_commit; commit_seq = SEQ_W'(c);
        #0.5;
        chk(rename_grant === 1'b0, "R7 no grant during squash request", int'(rename_grant), 0);
        @(posedge clk); #1;
        squash_valid = 1'b0; commit_valid = 1'b0;
        @(negedge clk);
        chk(busy === 1'b1, "R8 busy after squash", int'(busy), 1);
        chk(rename_grant === 1'b0, "R7 no grant while busy", int'(rename_grant), 0);
        wait_idle();
    endtask

    task automatic do_commit(input int c, input bit pause);
        int n;
        n = model_release(c);
        @(negedge clk);
        commit_valid = 1'b1; commit_seq = SEQ_W'(c);
        @(posedge clk); #1;
        commit_valid = 1'b0;
        @(negedge clk);
        if (n == 0) begin
            chk(busy === 1'b0, "R5 stale commit leaves busy low", int'(busy), 0);
        end else begin
            chk(busy === 1'b1, "R8 busy after commit", int'(busy), 1);
            if (pause) begin
                squashing = 1'b1;
                for (int k = 0; k < 2; k++) begin
                    @(negedge clk);
                    chk(fl_ret_valid === 1'b0, "R6 release paused by squashing", int'(fl_ret_valid), 0);
                    chk(busy === 1'b1, "R6 walk held while squashing", int'(busy), 1);
                end
                squashing = 1'b0;
            end
            wait_idle();
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0, "R9 reset busy", int'(busy), 0);
        chk(rename_grant === 1'b1, "R9 reset grant with registers free", int'(rename_grant), 1);
        chk(!(map_wr_valid || fl_ret_valid || sb_set_valid || sb_clr_valid),
            "R9 reset pulses low", int'(fl_ret_valid), 0);

        // R7: too few free registers for the destinations
        free_count = 8'd2; rec_dst_count = 2'd3;
        #0.5;
        chk(rename_grant === 1'b0, "R7 free_count below need", int'(rename_grant), 0);
        free_count = 8'd3;
        #0.5;
        chk(rename_grant === 1'b1, "R7 free_count equals need", int'(rename_grant), 1);

        // R1 records, the youngest taking a special register index (>= NUM_PHYS)
        record(10, 1, 40, 1);
        record(20, 2, 41, 2);
        record(30, 3, 42, 3);
        record(40, 4, 43, 4);
        record(50, 5, 100, 5);

        // R2 and R3 rollback of seq 50 and 40
        do_squash(30, 1'b0, 0);
        // R5 stale commit: oldest is 10 > 5
        do_commit(5, 1'b0);
        // R4 release of 10 and 20
        do_commit(20, 1'b0);
        // R6 commit in the same cycle as a squash that removes nothing
        do_squash(1000, 1'b1, 30);
        // R6 commit while squashing is high
        @(negedge clk);
        squashing = 1'b1; commit_valid = 1'b1; commit_seq = 16'd30;
        @(posedge clk); #1;
        commit_valid = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0, "R6 commit during squashing dropped", int'(busy), 0);
        squashing = 1'b0;

        // fill to DEPTH records
        for (int i = 0; i < 7; i++) record(60 + 10*i, 6 + i, 50 + i, 10 + i);
        @(negedge clk);
        free_count = 8'd20; rec_dst_count = 2'd1;
        #0.5;
        chk(rename_grant === 1'b0, "R7 no grant when full", int'(rename_grant), 0);

        // R4 and R6 release with a pause while squashing is high
        do_commit(80, 1'b1);
        do_commit(5000, 1'b0);
        // R5 commit on an empty journal
        do_commit(6000, 1'b0);
        // R8 squash on an empty journal still walks one cycle
        do_squash(0, 1'b0, 0);

        repeat (3) @(negedge clk);
        chk(expq.size() == 0, "R2/R4 all expected items seen", expq.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule